// File: doc/BRIEF.md
# DDS Serial Command Word Decoder

This block receives 16-bit command words on a three-wire serial link and keeps the tuning state of a direct digital synthesis core up to date. The state covers two 32-bit frequency words, four 12-bit phase words, a frequency/phase selection and two groups of control flags. The serial clock, the active-low select and the data line are brought into the system clock domain and oversampled. Each word is decoded when the select line is released. A word of any other length than 16 bits is dropped.

Tuning words are written in two steps. A staging command puts one byte into a shared hold register. A following commit command joins that held byte with its own byte and writes the 16-bit pair into one half of a frequency word, or into a whole phase word, in a single clock cycle. The synthesis core therefore never sees a tuning word in which only one byte has changed. A full 32-bit frequency load is four words: stage the top byte address, commit the next address down, then stage and commit the lower pair.

Top module: `dds_cmd_decoder`

## Requirements
- R1: Bits are shifted in MSB first on rising serial clock edges while the select is low. On select release a 16-bit word is decoded as opcode [15:12], address [11:8] and data [7:0].
- R2: A frame that ends with any bit count other than 16 changes no output.
- R3: Opcodes 0x3 and 0x1 load only the hold byte. No frequency or phase output changes.
- R4: Opcode 0x2 at an address a with a[3]=0 writes {hold, data} into frequency word a[2], upper half if a[1]=1, lower half if a[1]=0. Address bit 0 is ignored.
- R5: Opcode 0x0 at an address a with a[3]=1 writes the low 12 bits of {hold, data} into phase word a[2:1]. The upper four hold bits are dropped.
- R6: A frequency commit with a[3]=1, or a phase commit with a[3]=0, changes no output.
- R7: Opcode 0x6 sets the frequency select from bit 11 and the phase select from bits [10:9].
- R8: A word whose bits [15:14] are 10 sets the sync flag from bit 13 and the source-select flag from bit 12.
- R9: A word whose bits [15:14] are 11 sets sleep from bit 13, reset from bit 12 and clear from bit 11.
- R10: Opcodes 0x4, 0x5 and 0x7 change no output.
- R11: After reset, sleep, reset and clear are 1. All tuning words, selections, sync and source-select are 0.
- R12: The hold byte persists. A commit that has no new stage before it uses the last staged byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| csN | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data in |
| freqWords | output | 2x32 | Committed frequency words |
| phaseWords | output | 4x12 | Committed phase words |
| freqSel | output | 1 | Frequency word select |
| phaseSel | output | 2 | Phase word select |
| syncFlag | output | 1 | Sync control flag |
| srcSelFlag | output | 1 | Source-select control flag |
| sleepFlag | output | 1 | Sleep control flag |
| resetFlag | output | 1 | Core reset control flag |
| clearFlag | output | 1 | Clear control flag |

## Verification
Full four-word frequency loads are sent to both frequency words, and a check after every word shows that a staged byte never appears on the outputs before its commit. Commits are sent at odd addresses and without a new stage, which shows that address bit 0 and the age of the hold byte have no effect on where the data goes. Phase commits are made with held bytes whose upper nibble is set, and commits are sent to the wrong half of the address map, which separates a correct 12-bit truncation from a misrouted write. Frames of 15 and 17 bits are followed by a clean 16-bit frame: the short and long frames must change nothing, and the clean frame shows that the receiver recovered.

// File: rtl/dds_cmd_pkg.sv
package dds_cmd_pkg;
  localparam int FRAME_BITS = 16;
  localparam int BYTE_W     = 8;
  localparam int FREQ_W     = 32;
  localparam int PHASE_W    = 12;
  localparam int NUM_FREQ   = 2;
  localparam int NUM_PHASE  = 4;

  localparam logic [3:0] OP_PH_COMMIT = 4'h0;
  localparam logic [3:0] OP_PH_STAGE  = 4'h1;
  localparam logic [3:0] OP_FR_COMMIT = 4'h2;
  localparam logic [3:0] OP_FR_STAGE  = 4'h3;
  localparam logic [3:0] OP_SELECT    = 4'h6;

  // Strobes passed from the decoder to the register datapath
  typedef struct packed {
    logic        stage;
    logic        freqCommit;
    logic        phaseCommit;
    logic        selWr;
    logic        syncWr;
    logic        pwrWr;
    logic [3:0]  addr;
    logic [7:0]  data;
    logic [4:0]  flags;   // word bits [13:9]
  } ctlStrobe_t;
endpackage

// File: rtl/dds_serial_rx.sv
module dds_serial_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  csN,
  input  logic                  mosi,
  output logic                  wordValid,
  output logic [FRAME_BITS-1:0] word
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);

  logic [SYNC_STAGES-1:0] sclkSync, csSync, mosiSync;
  logic sclkPrev, csPrev;
  logic [CNT_W-1:0] bitCnt;
  logic [FRAME_BITS-1:0] shiftReg;
  logic sclkS, csS, mosiS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
      csSync   <= {csSync[SYNC_STAGES-2:0], csN};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosi};
    end
  end

  assign sclkS = sclkSync[SYNC_STAGES-1];
  assign csS   = csSync[SYNC_STAGES-1];
  assign mosiS = mosiSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkPrev  <= 1'b0;
      csPrev    <= 1'b1;
      bitCnt    <= '0;
      shiftReg  <= '0;
      wordValid <= 1'b0;
    end else begin
      sclkPrev  <= sclkS;
      csPrev    <= csS;
      wordValid <= 1'b0;
      if (csS) begin
        if (!csPrev && bitCnt == CNT_W'(FRAME_BITS)) wordValid <= 1'b1;
        bitCnt <= '0;
      end else if (sclkS && !sclkPrev) begin
        shiftReg <= {shiftReg[FRAME_BITS-2:0], mosiS};
        if (bitCnt != '1) bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign word = shiftReg;
endmodule

// File: rtl/dds_cmd_ctrl.sv
module dds_cmd_ctrl
  import dds_cmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wordValid,
  input  logic [FRAME_BITS-1:0] word,
  output ctlStrobe_t            strobe
);
  ctlStrobe_t nxt;

  always_comb begin
    nxt       = '0;
    nxt.addr  = word[11:8];
    nxt.data  = word[7:0];
    nxt.flags = word[13:9];
    if (wordValid) begin
      case (word[15:12])
        OP_PH_COMMIT:             nxt.phaseCommit = word[11];
        OP_PH_STAGE, OP_FR_STAGE: nxt.stage       = 1'b1;
        OP_FR_COMMIT:             nxt.freqCommit  = !word[11];
        OP_SELECT:                nxt.selWr       = 1'b1;
        4'h8, 4'h9, 4'hA, 4'hB:   nxt.syncWr      = 1'b1;
        4'hC, 4'hD, 4'hE, 4'hF:   nxt.pwrWr       = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe <= '0;
    else        strobe <= nxt;
  end
endmodule

// File: rtl/dds_tune_regs.sv
module dds_tune_regs
  import dds_cmd_pkg::*;
#(
  parameter int FW = FREQ_W,
  parameter int PW = PHASE_W,
  parameter int NF = NUM_FREQ,
  parameter int NP = NUM_PHASE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  ctlStrobe_t             strobe,
  output logic [NF-1:0][FW-1:0]  freqWords,
  output logic [NP-1:0][PW-1:0]  phaseWords,
  output logic                   freqSel,
  output logic [1:0]             phaseSel,
  output logic                   syncFlag,
  output logic                   srcSelFlag,
  output logic                   sleepFlag,
  output logic                   resetFlag,
  output logic                   clearFlag
);
  localparam int HALF_W = FW / 2;

  logic [BYTE_W-1:0]   holdByte;
  logic [2*BYTE_W-1:0] pairVal;

  assign pairVal = {holdByte, strobe.data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            holdByte <= '0;
    else if (strobe.stage) holdByte <= strobe.data;
  end

  for (genvar f = 0; f < NF; f++) begin : g_freq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) freqWords[f] <= '0;
      else if (strobe.freqCommit && strobe.addr[2] == 1'(f)) begin
        if (strobe.addr[1]) freqWords[f][FW-1:HALF_W] <= pairVal;
        else                freqWords[f][HALF_W-1:0]  <= pairVal;
      end
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_phase
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phaseWords[p] <= '0;
      else if (strobe.phaseCommit && strobe.addr[2:1] == 2'(p))
        phaseWords[p] <= pairVal[PW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freqSel    <= 1'b0;
      phaseSel   <= 2'b00;
      syncFlag   <= 1'b0;
      srcSelFlag <= 1'b0;
      sleepFlag  <= 1'b1;
      resetFlag  <= 1'b1;
      clearFlag  <= 1'b1;
    end else begin
      if (strobe.selWr) begin
        freqSel  <= strobe.flags[2];
        phaseSel <= strobe.flags[1:0];
      end
      if (strobe.syncWr) begin
        syncFlag   <= strobe.flags[4];
        srcSelFlag <= strobe.flags[3];
      end
      if (strobe.pwrWr) begin
        sleepFlag <= strobe.flags[4];
        resetFlag <= strobe.flags[3];
        clearFlag <= strobe.flags[2];
      end
    end
  end
endmodule

// File: rtl/dds_cmd_decoder.sv
module dds_cmd_decoder
  import dds_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                sclk,
  input  logic                                csN,
  input  logic                                mosi,
  output logic [NUM_FREQ-1:0][FREQ_W-1:0]     freqWords,
  output logic [NUM_PHASE-1:0][PHASE_W-1:0]   phaseWords,
  output logic                                freqSel,
  output logic [1:0]                          phaseSel,
  output logic                                syncFlag,
  output logic                                srcSelFlag,
  output logic                                sleepFlag,
  output logic                                resetFlag,
  output logic                                clearFlag
);
  logic                  wordValid;
  logic [FRAME_BITS-1:0] rxWord;
  ctlStrobe_t            ctlStrobe;

  dds_serial_rx #(.SYNC_STAGES(SYNC_STAGES), .FRAME_BITS(FRAME_BITS)) rx_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csN(csN), .mosi(mosi),
    .wordValid(wordValid), .word(rxWord)
  );

  dds_cmd_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .wordValid(wordValid), .word(rxWord),
    .strobe(ctlStrobe)
  );

  dds_tune_regs regs_i (
    .clk(clk), .rst_n(rst_n), .strobe(ctlStrobe),
    .freqWords(freqWords), .phaseWords(phaseWords),
    .freqSel(freqSel), .phaseSel(phaseSel),
    .syncFlag(syncFlag), .srcSelFlag(srcSelFlag),
    .sleepFlag(sleepFlag), .resetFlag(resetFlag), .clearFlag(clearFlag)
  );
endmodule

// File: rtl/dds_cmd_decoder_chk.sv
module dds_cmd_decoder_chk
  import dds_cmd_pkg::*;
(
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_FREQ-1:0][FREQ_W-1:0]   freqWords,
  input logic [NUM_PHASE-1:0][PHASE_W-1:0] phaseWords,
  input logic                              freqSel,
  input logic [1:0]                        phaseSel,
  input logic                              syncFlag,
  input logic                              srcSelFlag,
  input logic                              sleepFlag,
  input logic                              resetFlag,
  input logic                              clearFlag,
  input ctlStrobe_t                        strobe
);
  // R11
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sleepFlag && resetFlag && clearFlag &&
                      freqWords == '0 && phaseWords == '0 && !freqSel));

  // R3
  stage_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.stage |=> ($stable(freqWords) && $stable(phaseWords)));

  // R4
  freq_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freqWords) |-> $past(strobe.freqCommit));

  // R5
  phase_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phaseWords) |-> $past(strobe.phaseCommit));

  // R7
  sel_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({freqSel, phaseSel}) |-> $past(strobe.selWr));

  // R8
  sync_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({syncFlag, srcSelFlag}) |-> $past(strobe.syncWr));

  // R9
  pwr_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({sleepFlag, resetFlag, clearFlag}) |-> $past(strobe.pwrWr));

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.stage, strobe.freqCommit, strobe.phaseCommit,
              strobe.selWr, strobe.syncWr, strobe.pwrWr}));
endmodule

bind dds_cmd_decoder dds_cmd_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .freqWords(freqWords), .phaseWords(phaseWords),
  .freqSel(freqSel), .phaseSel(phaseSel), .syncFlag(syncFlag),
  .srcSelFlag(srcSelFlag), .sleepFlag(sleepFlag), .resetFlag(resetFlag),
  .clearFlag(clearFlag), .strobe(ctlStrobe)
);

// File: tb/dds_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module dds_cmd_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic mosi = 1'b0;
  logic [1:0][31:0] freqWords;
  logic [3:0][11:0] phaseWords;
  logic freqSel, syncFlag, srcSelFlag, sleepFlag, resetFlag, clearFlag;
  logic [1:0] phaseSel;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dds_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csN(csN), .mosi(mosi),
    .freqWords(freqWords), .phaseWords(phaseWords), .freqSel(freqSel),
    .phaseSel(phaseSel), .syncFlag(syncFlag), .srcSelFlag(srcSelFlag),
    .sleepFlag(sleepFlag), .resetFlag(resetFlag), .clearFlag(clearFlag)
  );

  // Observation codes: 0/1 frequency word, 2..5 phase word, 6 control byte
  // control byte = {freqSel, phaseSel, sync, srcSel, sleep, reset, clear}
  function automatic logic [31:0] obsVal(input logic [3:0] o);
    case (o)
      4'd0: return freqWords[0];
      4'd1: return freqWords[1];
      4'd2: return {20'd0, phaseWords[0]};
      4'd3: return {20'd0, phaseWords[1]};
      4'd4: return {20'd0, phaseWords[2]};
      4'd5: return {20'd0, phaseWords[3]};
      default: return {24'd0, freqSel, phaseSel, syncFlag, srcSelFlag,
                       sleepFlag, resetFlag, clearFlag};
    endcase
  endfunction

  // {word, observation code, expected, requirement number}
  localparam int NV = 26;
  localparam logic [55:0] VECS [NV] = '{
    {16'h33AB, 4'd0, 32'h0000_0000, 4'd3},   // R3 stage top byte
    {16'h22CD, 4'd0, 32'hABCD_0000, 4'd4},   // R4 upper half
    {16'h3112, 4'd0, 32'hABCD_0000, 4'd3},   // R3
    {16'h2034, 4'd0, 32'hABCD_1234, 4'd4},   // R4 lower half
    {16'h3711, 4'd1, 32'h0000_0000, 4'd3},   // R3
    {16'h2622, 4'd1, 32'h1122_0000, 4'd4},   // R4
    {16'h3533, 4'd1, 32'h1122_0000, 4'd3},   // R3
    {16'h2444, 4'd1, 32'h1122_3344, 4'd4},   // R4
    {16'h2355, 4'd0, 32'h3355_1234, 4'd4},   // R4 odd address
    {16'h19FA, 4'd2, 32'h0000_0000, 4'd3},   // R3
    {16'h08BC, 4'd2, 32'h0000_0ABC, 4'd5},   // R5 upper nibble dropped
    {16'h1B07, 4'd3, 32'h0000_0000, 4'd3},   // R3
    {16'h0A65, 4'd3, 32'h0000_0765, 4'd5},   // R5
    {16'h1D0F, 4'd4, 32'h0000_0000, 4'd3},   // R3
    {16'h0CFF, 4'd4, 32'h0000_0FFF, 4'd5},   // R5
    {16'h0E21, 4'd5, 32'h0000_0F21, 4'd12},  // R12 reused hold byte
    {16'h0499, 4'd1, 32'h1122_3344, 4'd6},   // R6 phase commit, low addr
    {16'h2A77, 4'd3, 32'h0000_0765, 4'd6},   // R6 freq commit, high addr
    {16'h6C00, 4'd6, 32'h0000_00C7, 4'd7},   // R7
    {16'hA000, 4'd6, 32'h0000_00D7, 4'd8},   // R8
    {16'h9000, 4'd6, 32'h0000_00CF, 4'd8},   // R8
    {16'hC000, 4'd6, 32'h0000_00C8, 4'd9},   // R9
    {16'hE800, 4'd6, 32'h0000_00CD, 4'd9},   // R9
    {16'h4FFF, 4'd6, 32'h0000_00CD, 4'd10},  // R10
    {16'h5123, 4'd6, 32'h0000_00CD, 4'd10},  // R10
    {16'h7FFF, 4'd0, 32'h3355_1234, 4'd10}   // R10
  };

  task automatic sendBits(input logic [31:0] bits, input int n);
    csN = 1'b0;
    #20;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = bits[i];
      #20 sclk = 1'b1;
      #20 sclk = 1'b0;
    end
    #20 csN = 1'b1;
    repeat (12) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11", obsVal(4'd6), 32'h07);
    check("R11", obsVal(4'd0), 32'h0);
    check("R11", obsVal(4'd5), 32'h0);

    // R1 framing exercised by every table entry
    for (int v = 0; v < NV; v++) begin
      sendBits({16'h0, VECS[v][55:40]}, 16);
      check($sformatf("R%0d vec%0d", VECS[v][3:0], v), obsVal(VECS[v][39:36]), VECS[v][35:4]);
    end

    // R2 short frame: first 15 bits of a commit
    sendBits({17'h0, 15'(16'h2255 >> 1)}, 15);
    check("R2 short", obsVal(4'd0), 32'h3355_1234);
    // R2 long frame: 17 bits whose last 16 form a commit
    sendBits({16'h0, 16'h2255}, 17);
    check("R2 long", obsVal(4'd0), 32'h3355_1234);
    // R1 clean frame after bad ones; hold byte is 0x0F
    sendBits({16'h0, 16'h2255}, 16);
    check("R1 recover", obsVal(4'd0), 32'h0F55_1234);

    // R11 reset in mid-run
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R11 rerst", obsVal(4'd6), 32'h07);
    check("R11 rerst", obsVal(4'd1), 32'h0);
    check("R11 rerst", obsVal(4'd3), 32'h0);
    summary();
  end
endmodule